// File: doc/BRIEF.md
# Split-Word SHA-512 Sigma Function Unit

This unit serves a 32-bit processor that keeps every 64-bit SHA-512 quantity in two 32-bit registers. Each of the four SHA-512 rotate-and-XOR functions (the two big Sigma and the two small sigma functions) is evaluated as separate 32-bit operations. Each operation combines asymmetric shifts of two source words into one 32-bit half of the 64-bit answer. For the small sigma functions, the high and low halves differ by one term. The unit receives an instruction word together with its two source operands. It decodes which of the six operations is wanted and returns the matching 32-bit half.

A word that matches none of the six encodings is reported as illegal. So is a matching word issued while the core is not in 32-bit mode, or while the scalar SHA-512 hash feature is switched off. In both cases the returned value is zero. Inputs are taken on a valid strobe. The result, the illegal flag and an output valid strobe appear exactly one clock later from a single register stage.

Top module: `sha512_split_fu`

## Requirements
- R1: An operation is recognised only when insn[6:0] = 7'b0110011 and insn[14:12] = 3'b000. The operation is then chosen by insn[31:25]: 7'b0101000 hi-Sigma0 (sum0r), 7'b0101001 hi-Sigma1 (sum1r), 7'b0101010 sigma0 low (sig0l), 7'b0101110 sigma0 high (sig0h), 7'b0101011 sigma1 low (sig1l), 7'b0101111 sigma1 high (sig1h). Bits [24:15] and [11:7] do not matter.
- R2: sum0r returns (a<<25)^(a<<30)^(a>>28)^(b>>7)^(b>>2)^(b<<4). Here a is the first operand and b the second, both taken as unsigned 32-bit values. Right shifts fill with zeros, and bits shifted past bit 31 are dropped.
- R3: sum1r returns (b<<14)^(b<<18)^(b>>9)^(a>>18)^(a>>14)^(a<<23), with the same 32-bit shift rules.
- R4: sig0l returns (b<<24)^(b<<25)^(b<<31)^(a>>8)^(a>>7)^(a>>1).
- R5: sig0h returns the sig0l value without the b<<25 term.
- R6: sig1l returns (b<<13)^(b<<26)^(b>>29)^(a>>19)^(a>>6)^(a<<3).
- R7: sig1h returns the sig1l value without the b<<26 term.
- R8: A strobed word that fails R1 sets illegal and returns a result of zero. Examples are funct7 7'b0101100, a funct3 other than 000, or any other major opcode.
- R9: A word that passes R1 is still illegal, with a zero result, when mode32 is low or hash_en is low.
- R10: out_valid is high in exactly the cycle after each cycle in which in_valid is high. illegal is high only together with out_valid.
- R11: While rst_n is low at a clock edge, out_valid, illegal and result are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Captures insn and the operands this cycle |
| insn | input | 32 | Instruction word to decode |
| opnd_a | input | 32 | First source operand |
| opnd_b | input | 32 | Second source operand |
| mode32 | input | 1 | High when the core runs in 32-bit mode |
| hash_en | input | 1 | High when the scalar SHA-512 hash feature is enabled |
| out_valid | output | 1 | Result and illegal flag are valid |
| result | output | 32 | Computed 32-bit half, zero when illegal |
| illegal | output | 1 | Captured word was rejected |

## Verification
The hardest cases to reach from the ports are the single-term differences between the sigma high and low variants. Those terms vanish for almost any operand in which b carries few bits. The stimulus therefore walks a single set bit through every position of b, and separately of a, for all six operations. This way each individual term, and each bit that is truncated or zero-filled, shows up alone in the result. Near-miss encodings are also issued back to back with legal ones, so that a stale result or a stale illegal flag carried between items would be caught. These include funct7 0101100, a wrong funct3 and a wrong opcode, plus legal words with mode32 or hash_en low.

// File: rtl/sha512_split_pkg.sv
// Package: shared types and constants for the split-word SHA-512 unit.
// Assumes a 32-bit datapath; the shift amounts are fixed by the hash.
package sha512_split_pkg;

    localparam int DATA_W  = 32;
    localparam int INSN_W  = 32;
    localparam int OPC_W   = 7;
    localparam int F3_W    = 3;
    localparam int F7_W    = 7;

    localparam logic [OPC_W-1:0] OPC_REG = 7'b0110011;
    localparam logic [F3_W-1:0]  F3_HASH = 3'b000;

    localparam logic [F7_W-1:0] F7_SUM0R = 7'b0101000;
    localparam logic [F7_W-1:0] F7_SUM1R = 7'b0101001;
    localparam logic [F7_W-1:0] F7_SIG0L = 7'b0101010;
    localparam logic [F7_W-1:0] F7_SIG0H = 7'b0101110;
    localparam logic [F7_W-1:0] F7_SIG1L = 7'b0101011;
    localparam logic [F7_W-1:0] F7_SIG1H = 7'b0101111;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_SUM0R = 3'd1,
        OP_SUM1R = 3'd2,
        OP_SIG0L = 3'd3,
        OP_SIG0H = 3'd4,
        OP_SIG1L = 3'd5,
        OP_SIG1H = 3'd6
    } hash_op_e;

endpackage

// File: rtl/sha512_split_decode.sv
// Decoder: maps an instruction word onto one of six hash operations.
// Assumes combinational use; legality also needs 32-bit mode and the
// hash feature enable.
module sha512_split_decode
    import sha512_split_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic              mode32,
    input  logic              hash_en,
    output hash_op_e          op,
    output logic              legal
);

    logic [OPC_W-1:0] opc;
    logic [F3_W-1:0]  f3;
    logic [F7_W-1:0]  f7;
    logic             frame_ok;
    hash_op_e         raw_op;

    assign opc      = insn[OPC_W-1:0];
    assign f3       = insn[14:12];
    assign f7       = insn[INSN_W-1:INSN_W-F7_W];
    assign frame_ok = (opc == OPC_REG) && (f3 == F3_HASH);

    // Purpose: pick the operation from funct7 when the frame matches.
    always_comb begin
        raw_op = OP_NONE;
        if (frame_ok) begin
            case (f7)
                F7_SUM0R: raw_op = OP_SUM0R;
                F7_SUM1R: raw_op = OP_SUM1R;
                F7_SIG0L: raw_op = OP_SIG0L;
                F7_SIG0H: raw_op = OP_SIG0H;
                F7_SIG1L: raw_op = OP_SIG1L;
                F7_SIG1H: raw_op = OP_SIG1H;
                default:  raw_op = OP_NONE;
            endcase
        end
    end

    // Purpose: gate the operation with the mode and feature enables.
    always_comb begin
        legal = (raw_op != OP_NONE) && mode32 && hash_en;
        op    = legal ? raw_op : OP_NONE;
    end

endmodule

// File: rtl/sha512_split_mix.sv
// Datapath: evaluates one 32-bit half of a SHA-512 Sigma/sigma function
// from two operand words. Assumes unsigned operands with zero-fill right
// shifts; an OP_NONE select yields zero.
module sha512_split_mix
    import sha512_split_pkg::*;
(
    input  hash_op_e          op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    logic [DATA_W-1:0] s0r, s1r, g0_core, g0_extra, g1_core, g1_extra;

    // Purpose: big-Sigma halves, each mixing both operands.
    always_comb begin
        s0r = (a << 25) ^ (a << 30) ^ (a >> 28)
            ^ (b >> 7)  ^ (b >> 2)  ^ (b << 4);
        s1r = (a << 23) ^ (a >> 14) ^ (a >> 18)
            ^ (b >> 9)  ^ (b << 18) ^ (b << 14);
    end

    // Purpose: small-sigma terms shared by the high and low variants.
    always_comb begin
        g0_core  = (a >> 1) ^ (a >> 7) ^ (a >> 8) ^ (b << 31) ^ (b << 24);
        g0_extra = b << 25;
        g1_core  = (a << 3) ^ (a >> 6) ^ (a >> 19) ^ (b >> 29) ^ (b << 13);
        g1_extra = b << 26;
    end

    // Purpose: select the requested half.
    always_comb begin
        case (op)
            OP_SUM0R: y = s0r;
            OP_SUM1R: y = s1r;
            OP_SIG0L: y = g0_core ^ g0_extra;
            OP_SIG0H: y = g0_core;
            OP_SIG1L: y = g1_core ^ g1_extra;
            OP_SIG1H: y = g1_core;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/sha512_split_fu.sv
// Top: split-word SHA-512 function unit with one registered output stage.
// Assumes in_valid strobes one item per cycle; the result appears one
// cycle later, forced to zero when the word is rejected.
module sha512_split_fu
    import sha512_split_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              mode32,
    input  logic              hash_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              illegal
);

    hash_op_e          op;
    logic              legal;
    logic [DATA_W-1:0] mix_y;

    sha512_split_decode u_decode (
        .insn    (insn),
        .mode32  (mode32),
        .hash_en (hash_en),
        .op      (op),
        .legal   (legal)
    );

    sha512_split_mix u_mix (
        .op (op),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (mix_y)
    );

    // Purpose: register the result, illegal flag and output strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            illegal   <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                illegal <= !legal;
                result  <= legal ? mix_y : '0;
            end else begin
                illegal <= 1'b0;
            end
        end
    end

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !illegal));

    // R8
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0));

    // R9
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(mode32 && hash_en)) |=> illegal);

    // R1
    opcode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[OPC_W-1:0] != OPC_REG) |=> illegal);

endmodule

// File: tb/sha512_split_fu_bench.sv
module sha512_split_fu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        mode32 = 1'b1;
    logic        hash_en = 1'b1;
    logic        out_valid;
    logic [31:0] result;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit live = 0;

    typedef struct {
        logic [31:0] val;
        logic        ill;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    sha512_split_fu u_sha512_split_fu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .mode32(mode32), .hash_en(hash_en),
        .out_valid(out_valid), .result(result), .illegal(illegal)
    );

    localparam logic [6:0] F7S [6] = '{7'b0101000, 7'b0101001, 7'b0101010,
                                       7'b0101110, 7'b0101011, 7'b0101111};
    localparam string TAGS [6] = '{"R2", "R3", "R4", "R5", "R6", "R7"};

    function automatic logic [31:0] model(input logic [6:0] f7,
                                          input logic [31:0] a, input logic [31:0] b);
        logic [63:0] x, z, r;
        x = {32'd0, a};
        z = {32'd0, b};
        case (f7)
            7'b0101000: r = (x<<25)^(x<<30)^(x>>28)^(z>>7)^(z>>2)^(z<<4);
            7'b0101001: r = (x<<23)^(x>>14)^(x>>18)^(z>>9)^(z<<18)^(z<<14);
            7'b0101010: r = (x>>1)^(x>>7)^(x>>8)^(z<<31)^(z<<25)^(z<<24);
            7'b0101110: r = (x>>1)^(x>>7)^(x>>8)^(z<<31)^(z<<24);
            7'b0101011: r = (x<<3)^(x>>6)^(x>>19)^(z>>29)^(z<<26)^(z<<13);
            7'b0101111: r = (x<<3)^(x>>6)^(x>>19)^(z>>29)^(z<<13);
            default:    r = '0;
        endcase
        return r[31:0];
    endfunction

    task automatic check(input string tag, input bit ok,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Driver: present one item and push its expected outcome.
    task automatic drive(input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] b, input bit m, input bit e,
                         input bit ok, input string tag);
        exp_t it;
        @(negedge clk);
        in_valid = 1'b1; insn = w; opnd_a = a; opnd_b = b; mode32 = m; hash_en = e;
        it.ill = !(ok && m && e);
        it.val = it.ill ? 32'd0 : model(w[31:25], a, b);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        insn = $urandom;
    endtask

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3,
                                       input logic [6:0] opc);
        logic [31:0] r;
        r = $urandom;
        r[31:25] = f7; r[14:12] = f3; r[6:0] = opc;
        return r;
    endfunction

    // Monitor: compare after each edge against the scoreboard.
    always @(posedge clk) begin
        #1;
        if (live) begin
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                check({it.tag, "/R10 valid"}, out_valid === 1'b1, {31'd0, out_valid}, 32'd1);
                check({it.tag, " illegal"}, illegal === it.ill, {31'd0, illegal}, {31'd0, it.ill});
                check({it.tag, " result"}, result === it.val, result, it.val);
            end else begin
                check("R10 idle", out_valid === 1'b0 && illegal === 1'b0,
                      {30'd0, out_valid, illegal}, 32'd0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11: strobed input during reset must not show at the outputs
        @(negedge clk);
        in_valid = 1'b1; insn = mk(F7S[0], 3'b000, 7'b0110011); opnd_a = '1; opnd_b = '1;
        repeat (3) begin
            @(negedge clk);
            check("R11 reset", out_valid === 1'b0 && illegal === 1'b0 && result === 32'd0,
                  result, 32'd0);
        end
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        live = 1;

        for (int k = 0; k < 6; k++) begin
            drive(mk(F7S[k], 3'b000, 7'b0110011), 32'd0, 32'd0, 1, 1, 1, TAGS[k]);
            drive(mk(F7S[k], 3'b000, 7'b0110011), '1, '1, 1, 1, 1, TAGS[k]);
            for (int i = 0; i < 32; i++) begin
                drive(mk(F7S[k], 3'b000, 7'b0110011), 32'd0, 32'd1 << i, 1, 1, 1, TAGS[k]);
                drive(mk(F7S[k], 3'b000, 7'b0110011), 32'd1 << i, 32'd0, 1, 1, 1, TAGS[k]);
            end
            for (int i = 0; i < 40; i++) begin
                drive(mk(F7S[k], 3'b000, 7'b0110011), $urandom, $urandom, 1, 1, 1, TAGS[k]);
                if (i % 7 == 0) idle();
            end
        end

        // R8: near-miss encodings interleaved with legal ones
        for (int i = 0; i < 12; i++) begin
            drive(mk(F7S[i % 6], 3'b000, 7'b0110011), $urandom, $urandom, 1, 1, 1, "R1");
            drive(mk(7'b0101100, 3'b000, 7'b0110011), $urandom, $urandom, 1, 1, 0, "R8 f7");
            drive(mk(F7S[i % 6], 3'b001 + 3'(i % 7), 7'b0110011), $urandom, $urandom, 1, 1, 0, "R8 f3");
            drive(mk(F7S[i % 6], 3'b000, 7'b0010011), $urandom, $urandom, 1, 1, 0, "R8 opc");
            drive(mk(7'b0000000, 3'b000, 7'b0110011), $urandom, $urandom, 1, 1, 0, "R8 f7 zero");
        end

        // R9: legal words with mode or feature disabled
        for (int i = 0; i < 12; i++) begin
            drive(mk(F7S[i % 6], 3'b000, 7'b0110011), $urandom, $urandom, 0, 1, 1, "R9 mode32");
            drive(mk(F7S[i % 6], 3'b000, 7'b0110011), $urandom, $urandom, 1, 0, 1, "R9 hash_en");
            drive(mk(F7S[i % 6], 3'b000, 7'b0110011), $urandom, $urandom, 1, 1, 1, "R9 enabled");
        end

        idle();
        repeat (4) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule